// File: doc/BRIEF.md
# Oversampling Serial Receiver with Receive Queue

This block turns an asynchronous serial line into bytes. It watches the line through a two-stage synchroniser. It counts a shared tick that runs at sixteen times the bit rate, the same tick that times the companion transmitter. It then recovers each frame: a start bit, five to eight data bits sent least significant first, an optional parity bit and a stop bit.

Each recovered byte goes into a sixteen-entry queue together with three status flags: parity error, framing error and break. A consumer drains the queue through a valid/ready port. A frame that arrives while the queue is full is discarded. The loss is recorded in a sticky overrun flag that the host clears with a strobe.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset the read port shows no valid entry and the overrun flag is low.
- R2: A frame begins on a high-to-low transition of the synchronised line. Data bits are sampled every 16 ticks, starting 16 ticks after the confirmed start sample, and are assembled least significant bit first. `word_len_i` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused upper bits of the byte read as zero.
- R3: When `parity_en_i` is 1, one parity bit follows the data. With `parity_odd_i` = 0 the data and parity bits together hold an even number of ones. With `parity_odd_i` = 1 they hold an odd number. A mismatch sets the entry's parity error flag. With parity disabled the flag is 0 and no parity bit is expected.
- R4: The line is re-sampled 8 ticks after the falling edge. If it is high there, the event is a false start and no entry is produced.
- R5: A low first stop bit sets the entry's framing error flag. Only one stop bit is examined.
- R6: When every data bit, the parity bit (if enabled) and the stop bit are all 0, the entry's break flag and framing error flag are set. No further frame is recognised until the line has returned high.
- R7: Entries leave the queue in arrival order, up to 16 held at once. An entry is consumed on a cycle where `rd_valid_o` and `rd_ready_i` are both 1. While it is not consumed, the presented entry stays unchanged.
- R8: A frame that completes while the queue holds 16 entries is dropped, and `overrun_o` is set. `overrun_o` stays high until `overrun_clr_i` is pulsed. A new overrun in the same cycle as a clear takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high, asynchronous |
| tick16_i | input | 1 | One-cycle pulse at 16x bit rate |
| word_len_i | input | 2 | Data bit count minus 5 |
| parity_en_i | input | 1 | Expect a parity bit |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 even |
| rd_valid_o | output | 1 | Queue head is available |
| rd_ready_i | input | 1 | Consumer accepts the head |
| rd_data_o | output | 8 | Received byte, zero-filled |
| rd_perr_o | output | 1 | Parity error flag of the head |
| rd_ferr_o | output | 1 | Framing error flag of the head |
| rd_brk_o | output | 1 | Break flag of the head |
| overrun_o | output | 1 | Sticky loss indication |
| overrun_clr_i | input | 1 | Clears the overrun flag |

## Verification
The main sweep covers every word length combined with no parity, even parity and odd parity. Each combination carries sixteen data values, including all-zeros and all-ones within the width. Together these separate bit-order and zero-fill faults from parity sense errors. Within the sweep, some frames carry a deliberately wrong parity bit, so the parity flag must react to the line rather than to the configuration alone. Separate frames exercise a short low glitch, a low stop bit with nonzero data, and a held-low break followed by a normal frame. A burst of seventeen frames without draining shows that the seventeenth is dropped, that the sixteen survivors keep their order, and that the overrun flag is sticky and clearable.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } srx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_WAITH = 3'd5
  } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic fell_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fell_o  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic       fell_i,
  input  logic       tick_i,
  input  logic [1:0] word_len_i,
  input  logic       parity_en_i,
  input  logic       parity_odd_i,
  output logic       push_o,
  output srx_entry_t entry_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);

  srx_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              par_q, par_d;
  logic [IDX_W-1:0]  last_idx;
  logic              mid_bit;
  logic              brk_now;

  assign last_idx = IDX_W'(4) + IDX_W'(word_len_i);
  assign mid_bit  = tick_i && (cnt_q == FULL_LAST);
  assign brk_now  = ~level_i && (dat_q == '0) && (~parity_en_i || ~par_q);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    dat_d   = dat_q;
    par_d   = par_q;
    push_o  = 1'b0;
    entry_o = '{brk: brk_now, ferr: ~level_i,
                perr: parity_en_i && ((^dat_q ^ par_q) != parity_odd_i),
                data: dat_q};
    unique case (st_q)
      ST_IDLE: begin
        if (fell_i) begin
          st_d  = ST_START;
          cnt_d = '0;
          idx_d = '0;
          dat_d = '0;
          par_d = 1'b0;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (cnt_q == HALF_LAST) begin
            cnt_d = '0;
            st_d  = level_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (mid_bit) begin
          cnt_d        = '0;
          dat_d[idx_q] = level_i;
          if (idx_q == last_idx) begin
            st_d = parity_en_i ? ST_PAR : ST_STOP;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (mid_bit) begin
          cnt_d = '0;
          par_d = level_i;
          st_d  = ST_STOP;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (mid_bit) begin
          cnt_d  = '0;
          push_o = 1'b1;
          st_d   = brk_now ? ST_WAITH : ST_IDLE;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAITH: begin
        if (level_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      dat_q <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      dat_q <= dat_d;
      par_q <= par_d;
    end
  end

  // R2
  push_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> tick_i);

  // R6
  brk_implies_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && entry_o.brk) |-> entry_o.ferr);

  // R6
  no_frame_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAITH && !level_i) |=> (st_q == ST_WAITH));

  // R4
  false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && tick_i && cnt_q == HALF_LAST && level_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  srx_entry_t wdata_i,
  output logic       full_o,
  input  logic       pop_i,
  output logic       valid_o,
  output srx_entry_t rdata_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  srx_entry_t     mem_q [DEPTH];
  logic [AW-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW:0]    cnt_q, cnt_d;
  logic           wr_en, rd_en;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign wr_en   = push_i && !full_o;
  assign rd_en   = pop_i && valid_o;
  assign rdata_o = mem_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (wr_en) wptr_d = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    if (rd_en) rptr_d = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    if (wr_en && !rd_en) cnt_d = cnt_q + 1'b1;
    else if (rd_en && !wr_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> full_o);

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import srx_pkg::*;
#(
  parameter int unsigned OVS   = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick16_i,
  input  logic [1:0]        word_len_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_perr_o,
  output logic              rd_ferr_o,
  output logic              rd_brk_o,
  output logic              overrun_o,
  input  logic              overrun_clr_i
);
  logic       line_lvl, line_fell;
  logic       frm_push, q_full;
  srx_entry_t frm_entry, head;
  logic       ovr_q, ovr_d;

  srx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(rx_i),
    .level_o(line_lvl), .fell_o(line_fell)
  );

  srx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .level_i(line_lvl), .fell_i(line_fell),
    .tick_i(tick16_i), .word_len_i(word_len_i), .parity_en_i(parity_en_i),
    .parity_odd_i(parity_odd_i), .push_o(frm_push), .entry_o(frm_entry)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(frm_push), .wdata_i(frm_entry),
    .full_o(q_full), .pop_i(rd_ready_i), .valid_o(rd_valid_o), .rdata_o(head)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (frm_push && q_full) ovr_d = 1'b1;
    else if (overrun_clr_i) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign overrun_o = ovr_q;
  assign rd_data_o = head.data;
  assign rd_perr_o = head.perr;
  assign rd_ferr_o = head.ferr;
  assign rd_brk_o  = head.brk;

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_push && q_full) |=> overrun_o);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !overrun_clr_i) |=> overrun_o);

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o) && $stable(rd_ferr_o)));
endmodule

// File: tb/tb_serial_rx_fifo.sv
module tb_serial_rx_fifo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx;
  logic       tick;
  logic [1:0] wl;
  logic       pen, podd;
  logic       rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, ovr, ovr_clr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam int BITCLK = 32; // 16 ticks x 2 clocks

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;
  end

  serial_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick16_i(tick),
    .word_len_i(wl), .parity_en_i(pen), .parity_odd_i(podd),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr), .rd_brk_o(rd_brk),
    .overrun_o(ovr), .overrun_clr_i(ovr_clr)
  );

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit badpar, input bit stopv);
    int n;
    logic [7:0] m;
    n = 5 + int'(wl);
    m = d & 8'((1 << n) - 1);
    rx = 1'b0; clocks(BITCLK);
    for (int i = 0; i < n; i++) begin rx = m[i]; clocks(BITCLK); end
    if (pen) begin rx = (^m) ^ podd ^ badpar; clocks(BITCLK); end
    rx = stopv; clocks(BITCLK);
    rx = 1'b1; clocks(BITCLK);
  endtask

  task automatic pop_chk(input string req, input logic [7:0] d,
                         input bit pe, input bit fe, input bit bk);
    @(negedge clk);
    check(rd_valid === 1'b1, req, "valid", rd_valid, 1);
    check(rd_data === d, req, "data", rd_data, d);
    check(rd_perr === pe, req, "perr", rd_perr, pe);
    check(rd_ferr === fe, req, "ferr", rd_ferr, fe);
    check(rd_brk === bk, req, "brk", rd_brk, bk);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] dv, mask;
    bit bp;
    rst_n = 1'b0; rx = 1'b1; wl = 2'd3; pen = 1'b0; podd = 1'b0;
    rd_ready = 1'b0; ovr_clr = 1'b0;
    clocks(5);
    rst_n = 1'b1;
    clocks(5);
    // R1 reset state
    check(rd_valid === 1'b0, "R1", "valid after reset", rd_valid, 0);
    check(ovr === 1'b0, "R1", "overrun after reset", ovr, 0);

    // R2 R3 sweep: word lengths x parity modes x data values
    for (int w = 0; w < 4; w++) begin
      for (int pm = 0; pm < 3; pm++) begin
        wl = 2'(w); pen = (pm != 0); podd = (pm == 2);
        mask = 8'((1 << (5 + w)) - 1);
        for (int k = 0; k < 16; k++) begin
          if (k == 0) dv = 8'h00;
          else if (k == 1) dv = 8'hFF;
          else dv = 8'(k * 37 + w * 11 + 5);
          bp = pen && (k % 5 == 2);
          send(dv, bp, 1'b1);
          // R2 zero-fill and LSB-first; R3 parity flag
          pop_chk(pen ? "R3" : "R2", dv & mask, bp, 1'b0, 1'b0);
        end
      end
    end

    // R4 false start: low for 3 ticks only
    wl = 2'd3; pen = 1'b0; podd = 1'b0;
    rx = 1'b0; clocks(6); rx = 1'b1; clocks(12 * BITCLK);
    check(rd_valid === 1'b0, "R4", "no entry after glitch", rd_valid, 0);
    send(8'h96, 1'b0, 1'b1);
    pop_chk("R4", 8'h96, 1'b0, 1'b0, 1'b0);

    // R5 low stop bit with nonzero data
    send(8'h3C, 1'b0, 1'b0);
    pop_chk("R5", 8'h3C, 1'b0, 1'b1, 1'b0);
    pen = 1'b1; podd = 1'b1;
    send(8'h81, 1'b0, 1'b0);
    pop_chk("R5", 8'h81, 1'b0, 1'b1, 1'b0);

    // R6 break: all low, held for a long time, then a normal frame
    pen = 1'b1; podd = 1'b0;
    rx = 1'b0; clocks(14 * BITCLK); rx = 1'b1; clocks(2 * BITCLK);
    pop_chk("R6", 8'h00, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    check(rd_valid === 1'b0, "R6", "single break entry", rd_valid, 0);
    send(8'h5A, 1'b0, 1'b1);
    pop_chk("R6", 8'h5A, 1'b0, 1'b0, 1'b0);

    // R7 R8 fill past depth without draining
    pen = 1'b0;
    for (int j = 0; j < 17; j++) begin
      send(8'(j * 13 + 1), 1'b0, 1'b1);
      if (j == 15)
        check(ovr === 1'b0, "R8", "no overrun at exactly full", ovr, 0);
    end
    check(ovr === 1'b1, "R8", "overrun after drop", ovr, 1);
    clocks(40);
    check(rd_data === 8'h01, "R7", "head held while not ready", rd_data, 8'h01);
    for (int j = 0; j < 16; j++) pop_chk("R7", 8'(j * 13 + 1), 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(rd_valid === 1'b0, "R8", "17th frame dropped", rd_valid, 0);
    check(ovr === 1'b1, "R8", "overrun sticky", ovr, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    check(ovr === 1'b0, "R8", "overrun cleared", ovr, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule